// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Band, Trip and Chopper

This block produces one pair of pulse-width-modulated outputs, A and B, from a free-running up-counter. Output A is high from the start of each period until the counter reaches a compare value, and B starts as the inverse of A. Each output then passes through its own edge-delay stage, which holds off the output's rising edge. A's delay separates B switching off from A switching on, and B's delay separates A switching off from B switching on. This creates the dead-band that protects a half-bridge from shoot-through.

After the dead-band, an optional carrier derived from the clock chops both outputs. Software can then override the level of either output. A fault (trip) stage sits last and has priority over everything else. It reacts in the same cycle as a fault input and forces each output low, high, or high-impedance. The trip either releases at the next period boundary (cycle-by-cycle mode) or stays latched until software clears it (one-shot mode). An event prescaler turns every Nth period wrap into a one-cycle interrupt pulse.

All settings arrive over a plain register write port of one word per cycle. The block has no streaming data interface, so there is no valid/ready handshake and no back-pressure: every write with `cfg_we` high takes effect at that clock edge. The register map is: 0 period, 1 compare A, 2 delays (rising delay for A in bits [7:0], rising delay for B in bits [15:8]), 3 trip setup, 4 override, 5 chopper, 6 event divisor, 7 control (bit 0 = run). Fields unused by a register are ignored.

Top module: `pwm_dbtrip_pair`

## Requirements
- R1: While running, the counter counts up from 0 to the active period and then returns to 0. A period write goes to a shadow copy that becomes active only when the counter wraps, so the period in progress completes with the old value.
- R2: Before the dead-band, A is high exactly while the counter is below compare A. B is high exactly while A is low. A compare of 0 keeps A low, and a compare above the period keeps A high.
- R3: A's rising edge is delayed by the register 2 bits [7:0] cycle count, and B's rising edge is delayed by the bits [15:8] count. Falling edges are not delayed, and a delay of 0 passes the edge straight through.
- R4: An output pulse that is shorter than or equal to its rising delay never appears.
- R5: In cycle-by-cycle mode (register 3 bit 0 = 0), any high `trip_in` bit forces the outputs in the same cycle. The force holds until the first counter wrap that occurs after all trip inputs are low.
- R6: In one-shot mode (register 3 bit 0 = 1), a trip stays latched across period wraps. It releases only when register 3 is written with bit 5 = 1, and bit 5 is not stored.
- R7: While a trip is active, each output takes its 2-bit force code: A from register 3 bits [2:1], B from bits [4:3]. Code 0 drives low, code 1 drives high, and codes 2 and 3 deassert that output's enable (high-impedance). With no trip active, both enables are high.
- R8: Register 4 bits 0/1 give override enable/level for A, and bits 2/3 give the same for B. An override takes effect on the cycle after the write. A trip takes priority over an override.
- R9: With register 5 bit 0 set, both outputs are ANDed with a carrier that is high for d+1 cycles and low for d+1 cycles, where d is register 5 bits [4:1].
- R10: With divisor N in register 6 bits [3:0] (N > 0), `irq` pulses for one cycle after every Nth counter wrap. N = 0 gives no pulses.
- R11: After reset, both outputs are low with enables high, `irq` is low, and every register is zero.
- R12: While register 7 bit 0 is 0, the counter holds, both outputs stay low, and no interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| trip_in | input | 2 | Fault inputs, active high, any bit trips |
| pwm_a | output | 1 | Output A level |
| pwm_a_oe | output | 1 | Output A drive enable (0 = high-impedance) |
| pwm_b | output | 1 | Output B level |
| pwm_b_oe | output | 1 | Output B drive enable (0 = high-impedance) |
| irq | output | 1 | Prescaled period-wrap event pulse |

## Verification
Most internal faults show up within one PWM period as a wrong number of high cycles per period on A or B. For example, a counter that skips its wrap, a compare that is off by one, or a delay counter that does not saturate all change the duty cycle. The bench therefore measures duty over exactly one period for a set of period, compare and delay combinations.

Trip latch faults appear differently:
- A cycle-by-cycle latch that clears too early shows up as an output recovering before the period boundary.
- A one-shot latch that leaks shows up as an output recovering tens of cycles later with no clear write.

A shadow-period fault shifts the spacing of the first interrupt after a period write by a full period.

// File: rtl/pwm_dbt_pkg.sv
package pwm_dbt_pkg;

  typedef enum logic [2:0] {
    SEL_PERIOD = 3'd0,
    SEL_CMPA   = 3'd1,
    SEL_DELAY  = 3'd2,
    SEL_TRIP   = 3'd3,
    SEL_OVR    = 3'd4,
    SEL_CHOP   = 3'd5,
    SEL_EVT    = 3'd6,
    SEL_CTRL   = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    FRC_LOW  = 2'd0,
    FRC_HIGH = 2'd1,
    FRC_HIZ  = 2'd2,
    FRC_HIZ3 = 2'd3
  } force_e;

  localparam int LANES = 2;

endpackage

// File: rtl/pwm_dbt_timebase.sv
module pwm_dbt_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] prd_shadow;
  logic [CNT_W-1:0] prd_act;
  logic [CNT_W-1:0] cnt;

  assign wrap_o = run && (cnt >= prd_act);
  assign cnt_o  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_shadow <= '0;
      prd_act    <= '0;
      cnt        <= '0;
    end else begin
      if (prd_wr) prd_shadow <= prd_in;
      if (wrap_o) begin
        cnt     <= '0;
        prd_act <= prd_shadow;
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt == '0));  // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_o) |=> (cnt == $past(cnt) + 1'b1));  // R1
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable(prd_act));  // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));  // R12

endmodule

// File: rtl/pwm_dbt_edge_delay.sv
module pwm_dbt_edge_delay #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_in,
  input  logic [DB_W-1:0] dly,
  output logic            y_out
);

  logic [DB_W-1:0] held;

  assign y_out = x_in && (held >= dly);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
    end else if (!x_in) begin
      held <= '0;
    end else if (held < dly) begin
      held <= held + 1'b1;
    end
  end

  AST_RISE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((dly != '0) && $rose(x_in)) |-> !y_out);  // R3
  AST_FALL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(x_in) |-> !y_out);  // R3

endmodule

// File: rtl/pwm_dbt_trip.sv
module pwm_dbt_trip #(
  parameter int NTRIP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIP-1:0] trip_in,
  input  logic             oneshot,
  input  logic             os_clr,
  input  logic             wrap,
  output logic             active
);

  logic trip_any;
  logic cbc_q;
  logic os_q;

  assign trip_any = |trip_in;
  assign active   = trip_any | (oneshot ? os_q : cbc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cbc_q <= 1'b0;
      os_q  <= 1'b0;
    end else begin
      if (!oneshot && trip_any) cbc_q <= 1'b1;
      else if (wrap)            cbc_q <= 1'b0;
      if (oneshot && trip_any)  os_q <= 1'b1;
      else if (os_clr)          os_q <= 1'b0;
    end
  end

  AST_CBC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_q && wrap && !trip_any) |=> !cbc_q);  // R5
  AST_ONESHOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (os_q && !os_clr) |=> os_q);  // R6

endmodule

// File: rtl/pwm_dbt_evtdiv.sv
module pwm_dbt_evtdiv #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [EVT_W-1:0] div,
  output logic             irq
);

  logic [EVT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (evt && (div != '0)) begin
        if (({1'b0, seen} + 1'b1) >= {1'b0, div}) begin
          seen <= '0;
          irq  <= 1'b1;
        end else begin
          seen <= seen + 1'b1;
        end
      end
    end
  end

  AST_IRQ_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(evt));  // R10
  AST_IRQ_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> !irq);  // R10

endmodule

// File: rtl/pwm_dbtrip_pair.sv
module pwm_dbtrip_pair
  import pwm_dbt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DB_W   = 8,
  parameter int CHOP_W = 4,
  parameter int EVT_W  = 4,
  parameter int NTRIP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic [NTRIP-1:0] trip_in,
  output logic             pwm_a,
  output logic             pwm_a_oe,
  output logic             pwm_b,
  output logic             pwm_b_oe,
  output logic             irq
);

  localparam int DATA_W   = CNT_W;
  localparam int FALL_LSB = DATA_W / 2;

  reg_sel_e sel;
  assign sel = reg_sel_e'(cfg_addr);

  logic [CNT_W-1:0]  cmpa_q;
  logic [DB_W-1:0]   dly_q   [LANES];
  logic              oneshot_q;
  force_e            frc_q   [LANES];
  logic              ovr_en_q  [LANES];
  logic              ovr_lvl_q [LANES];
  logic              chop_en_q;
  logic [CHOP_W-1:0] chop_div_q;
  logic [EVT_W-1:0]  evt_div_q;
  logic              run_q;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpa_q     <= '0;
      oneshot_q  <= 1'b0;
      chop_en_q  <= 1'b0;
      chop_div_q <= '0;
      evt_div_q  <= '0;
      run_q      <= 1'b0;
      for (int i = 0; i < LANES; i++) begin
        dly_q[i]     <= '0;
        frc_q[i]     <= FRC_LOW;
        ovr_en_q[i]  <= 1'b0;
        ovr_lvl_q[i] <= 1'b0;
      end
    end else if (cfg_we) begin
      case (sel)
        SEL_CMPA:  cmpa_q <= cfg_wdata;
        SEL_DELAY: begin
          dly_q[0] <= cfg_wdata[DB_W-1:0];
          dly_q[1] <= cfg_wdata[FALL_LSB +: DB_W];
        end
        SEL_TRIP: begin
          oneshot_q <= cfg_wdata[0];
          frc_q[0]  <= force_e'(cfg_wdata[2:1]);
          frc_q[1]  <= force_e'(cfg_wdata[4:3]);
        end
        SEL_OVR: begin
          ovr_en_q[0]  <= cfg_wdata[0];
          ovr_lvl_q[0] <= cfg_wdata[1];
          ovr_en_q[1]  <= cfg_wdata[2];
          ovr_lvl_q[1] <= cfg_wdata[3];
        end
        SEL_CHOP: begin
          chop_en_q  <= cfg_wdata[0];
          chop_div_q <= cfg_wdata[CHOP_W:1];
        end
        SEL_EVT:  evt_div_q <= cfg_wdata[EVT_W-1:0];
        SEL_CTRL: run_q <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  logic             prd_wr;
  logic             os_clr;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             trip_act;

  assign prd_wr = cfg_we && (sel == SEL_PERIOD);
  assign os_clr = cfg_we && (sel == SEL_TRIP) && cfg_wdata[5];

  pwm_dbt_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .prd_wr (prd_wr),
    .prd_in (cfg_wdata),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pwm_dbt_trip #(.NTRIP(NTRIP)) u_trip (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip_in (trip_in),
    .oneshot (oneshot_q),
    .os_clr  (os_clr),
    .wrap    (wrap),
    .active  (trip_act)
  );

  pwm_dbt_evtdiv #(.EVT_W(EVT_W)) u_evtdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (wrap),
    .div   (evt_div_q),
    .irq   (irq)
  );

  // carrier: high for div+1 cycles, low for div+1 cycles
  logic [CHOP_W-1:0] chop_cnt;
  logic              carrier;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chop_cnt <= '0;
      carrier  <= 1'b0;
    end else if (chop_cnt >= chop_div_q) begin
      chop_cnt <= '0;
      carrier  <= ~carrier;
    end else begin
      chop_cnt <= chop_cnt + 1'b1;
    end
  end

  logic a_raw;
  logic raw    [LANES];
  logic db     [LANES];
  logic lvl    [LANES];
  logic oe     [LANES];

  assign a_raw  = run_q && (cnt < cmpa_q);
  assign raw[0] = a_raw;
  assign raw[1] = run_q && !a_raw;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic chopped;
    logic ovr_lvl;

    pwm_dbt_edge_delay #(.DB_W(DB_W)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .x_in  (raw[g]),
      .dly   (dly_q[g]),
      .y_out (db[g])
    );

    assign chopped = chop_en_q ? (db[g] && carrier) : db[g];
    assign ovr_lvl = ovr_en_q[g] ? ovr_lvl_q[g] : chopped;

    always_comb begin
      if (trip_act) begin
        oe[g]  = !frc_q[g][1];
        lvl[g] = !frc_q[g][1] && frc_q[g][0];
      end else begin
        oe[g]  = 1'b1;
        lvl[g] = ovr_lvl;
      end
    end
  end

  assign pwm_a    = lvl[0];
  assign pwm_a_oe = oe[0];
  assign pwm_b    = lvl[1];
  assign pwm_b_oe = oe[1];

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !trip_act && !ovr_en_q[0] && !ovr_en_q[1]) |-> (!pwm_a && !pwm_b));  // R12
  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !$past(run_q)) |-> !irq);  // R12

endmodule

// File: tb/pwm_dbtrip_pair_bench.sv
`timescale 1ns/1ps
module pwm_dbtrip_pair_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  trip_in = '0;
  logic        pwm_a, pwm_a_oe, pwm_b, pwm_b_oe, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dbtrip_pair u_pwm_dbtrip_pair (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trip_in(trip_in), .pwm_a(pwm_a),
    .pwm_a_oe(pwm_a_oe), .pwm_b(pwm_b), .pwm_b_oe(pwm_b_oe), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr[2:0]; cfg_wdata = data[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int ca, output int cb, output int ci, output int rises);
    logic prev;
    ca = 0; cb = 0; ci = 0; rises = 0;
    prev = pwm_a;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ca += int'(pwm_a);
      cb += int'(pwm_b);
      ci += int'(irq);
      if (pwm_a && !prev) rises++;
      prev = pwm_a;
    end
  endtask

  task automatic wait_irq();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!irq && guard < 200);
  endtask

  // period, compare, rise delay A, rise delay B, A highs, B highs per period
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{ 9,  4, 0, 0,  4,  6},   // R2 plain duty
    '{ 9,  4, 2, 1,  2,  5},   // R3 both delays
    '{ 9,  0, 0, 3,  0, 10},   // R2 compare zero
    '{ 9, 12, 2, 2, 10,  0},   // R2 compare above period
    '{ 7,  3, 5, 0,  0,  5},   // R4 short pulse swallowed
    '{15,  8, 3, 3,  5,  5},   // R3 symmetric delays
    '{ 4,  2, 1, 1,  1,  2}    // R3 short period
  };

  initial begin
    int ca, cb, ci, rs, k;
    tick(3);
    rst_n = 1'b1;
    #1;
    chk(pwm_a == 0 && pwm_b == 0, "R11 reset levels", {pwm_a, pwm_b}, 0);
    chk(pwm_a_oe && pwm_b_oe, "R11 reset enables", {pwm_a_oe, pwm_b_oe}, 3);
    chk(irq == 0, "R11 reset irq", irq, 0);

    // stopped: nothing moves
    wr(0, 9); wr(1, 4); wr(6, 1);
    tick(20);
    measure(30, ca, cb, ci, rs);
    chk(ca == 0 && cb == 0, "R12 idle outputs", ca + cb, 0);
    chk(ci == 0, "R12 idle irq", ci, 0);
    wr(6, 0);
    wr(7, 1);

    for (int v = 0; v < NV; v++) begin
      wr(0, VEC[v][0]);
      wr(1, VEC[v][1]);
      wr(2, VEC[v][2] | (VEC[v][3] << 8));
      tick(40);
      measure(VEC[v][0] + 1, ca, cb, ci, rs);
      chk(ca == VEC[v][4], $sformatf("R2/R3/R4 vec%0d A highs", v), ca, VEC[v][4]);
      chk(cb == VEC[v][5], $sformatf("R2/R3/R4 vec%0d B highs", v), cb, VEC[v][5]);
    end

    // R1: shadowed period
    wr(2, 0); wr(1, 4); wr(0, 9); wr(6, 1);
    tick(30);
    wait_irq();
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 16'd3;
    @(negedge clk);
    cfg_we = 1'b0;
    k = 1;
    while (!irq && k < 100) begin @(negedge clk); k++; end
    chk(k == 10, "R1 old period completes", k, 10);
    k = 0;
    do begin @(negedge clk); k++; end while (!irq && k < 100);
    chk(k == 4, "R1 new period after wrap", k, 4);

    // R10: prescaler
    wr(0, 9); wr(6, 3);
    tick(40);
    measure(90, ca, cb, ci, rs);
    chk(ci == 3, "R10 divide by 3", ci, 3);
    wr(6, 0);
    tick(2);
    measure(90, ca, cb, ci, rs);
    chk(ci == 0, "R10 divisor zero", ci, 0);

    // R5: cycle-by-cycle trip, A forced low, B forced high
    wr(1, 12); wr(3, 8); wr(6, 1);
    tick(30);
    wait_irq();            // counter at 0
    tick(2);
    trip_in = 2'b01;
    #1;
    chk(pwm_a == 0 && pwm_b == 1, "R5 immediate force", {pwm_a, pwm_b}, 1);
    tick(2);
    trip_in = 2'b00;
    tick(3);               // counter 7
    chk(pwm_a == 0, "R5 held after release", pwm_a, 0);
    tick(3);               // counter 0 of next period
    chk(pwm_a == 1 && pwm_b == 0, "R5 release at wrap", {pwm_a, pwm_b}, 2);
    wr(6, 0);

    // R6/R7: one-shot, A forced high, B high-impedance
    wr(1, 0); wr(3, 1 | (1 << 1) | (2 << 3));
    tick(20);
    @(negedge clk);
    trip_in = 2'b10;
    #1;
    chk(pwm_a == 1 && pwm_b_oe == 0, "R7 force high and hi-z", {pwm_a, pwm_b_oe}, 2);
    chk(pwm_a_oe == 1, "R7 A enable kept", pwm_a_oe, 1);
    @(negedge clk);
    trip_in = 2'b00;
    tick(30);
    chk(pwm_a == 1 && pwm_b_oe == 0, "R6 latched across wraps", {pwm_a, pwm_b_oe}, 2);
    wr(3, 1 | (1 << 1) | (2 << 3) | (1 << 5));
    #1;
    chk(pwm_a == 0 && pwm_b == 1 && pwm_b_oe == 1, "R6 cleared by write",
        {pwm_a, pwm_b, pwm_b_oe}, 3);

    // R8: override and trip priority
    wr(3, 0);
    wr(4, 4'b0111);
    #1;
    chk(pwm_a == 1 && pwm_b == 0, "R8 override levels", {pwm_a, pwm_b}, 2);
    @(negedge clk);
    trip_in = 2'b01;
    #1;
    chk(pwm_a == 0 && pwm_b == 0, "R8 trip beats override", {pwm_a, pwm_b}, 0);
    @(negedge clk);
    trip_in = 2'b00;
    tick(25);
    chk(pwm_a == 1, "R8 override after trip", pwm_a, 1);
    wr(4, 0);
    #1;
    chk(pwm_a == 0 && pwm_b == 1, "R8 override removed", {pwm_a, pwm_b}, 1);

    // R9: chopper, carrier half period 3
    wr(1, 12); wr(5, 1 | (2 << 1));
    tick(20);
    measure(12, ca, cb, ci, rs);
    chk(ca == 6, "R9 chopped duty", ca, 6);
    chk(rs == 2, "R9 carrier edges", rs, 2);
    wr(5, 0);
    tick(5);
    measure(12, ca, cb, ci, rs);
    chk(ca == 12, "R9 chopper off", ca, 12);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule